// File: doc/BRIEF.md
# System Management Memory Window Decoder

This block sits in the address decode path of a host bridge. It decides, for every processor memory access, whether the access may reach the protected system-management memory. It also decides whether the access goes to DRAM or to the external bus, and which DRAM address it uses. Two 8-bit registers set its behaviour: a control register and an extension register. Both are written and read through a small configuration port.

There are three protected windows:

- **Legacy window.** The 128 KiB region from 0xA0000 to 0xBFFFF.
- **High alias.** An optional 384 KiB view at 0x100A0000. It is translated down onto DRAM starting at 0xA0000.
- **Top segment.** Carved from the highest DRAM addresses, with a size chosen from four encodings.

A one-way lock freezes the control register, except for its close bit, until the next reset. Routing is purely combinational from the access inputs, the register contents and the top-of-memory input. Register writes become visible after the next rising clock edge.

Top module: `smm_window_ctl`

## Requirements
- R1: After reset the control register (config address 0) reads 0x02 and the extension register (config address 1) reads 0x00; config addresses 2 and 3 always read 0x00.
- R2: Control register fields are: bit 6 open, bit 5 close, bit 4 lock, bit 3 enable, bits 2:0 a fixed segment code. While unlocked, a control write loads bits 6:3 and leaves bits 2:0 at 3'b010. Bit 7 of the control register and bits 6:3 of the extension register always read zero. An extension write stores bits 7, 2:1 and 0.
- R3: An unlocked control write with bit 4 set raises the lock and leaves the open bit at zero, in the same write.
- R4: While locked, a control write changes only the close bit (bit 5); all other control bits keep their values until reset, and reset clears the lock.
- R5: Outside system-management mode, a legacy-window access goes to DRAM only when control bits 6:4 are 3'b100; otherwise it goes to the bus.
- R6: In system-management mode, with enable set, a legacy-window read always goes to DRAM; a write goes to DRAM when close is 0 and to the bus when close is 1.
- R7: With control bit 3 clear, every access to the legacy window or the high alias goes to the bus, in or out of system-management mode.
- R8: With extension bit 7 set, host addresses 0x100A0000..0x100FFFFF form the protected window with DRAM address equal to host address minus 0x10000000, and 0xA0000..0xBFFFF then go to the bus.
- R9: The top segment exists only when control bit 3 and extension bit 0 are both 1. Its size is 128 KiB shifted left by extension bits 2:1, and it spans from top-of-memory minus its size up to top-of-memory.
- R10: A top-segment access goes to DRAM in system-management mode and to the bus outside it.
- R11: Any other address goes to DRAM with an untranslated address when below top-of-memory and to the bus otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| acc_addr | input | 32 | Host address of the current access |
| acc_smm | input | 1 | Access issued in system-management mode |
| acc_write | input | 1 | Access is a write (0 = read) |
| tom | input | 32 | Top of installed DRAM, byte address |
| route_dram | output | 1 | 1 = access goes to DRAM, 0 = to the bus |
| dram_addr | output | 32 | DRAM address, translated inside the high alias |

## Verification
The hardest states to reach are those behind the lock. Once the lock is set, only reset can undo it, and a random writer sets it almost at once and then spends the rest of the run in the frozen state. The stimulus therefore clears the lock bit from most random control writes and inserts occasional resets. This lets open, close and enable combinations be revisited both before and after locking. Directed steps also place access addresses exactly on the first and last byte of each top-segment size, to probe the window edges.

// File: rtl/smm_win_pkg.sv
package smm_win_pkg;

   // Control register layout (bit positions are decoded by the route logic)
   typedef struct packed {
      logic       rsvd;
      logic       open;
      logic       cls;
      logic       lck;
      logic       en;
      logic [2:0] seg;
   } smm_ctrl_t;

   // Extension register layout
   typedef struct packed {
      logic       alias_on;
      logic [3:0] rsvd;
      logic [1:0] tsize;
      logic       tseg_on;
   } smm_ext_t;

   localparam logic [2:0] SEG_CODE_DEF = 3'b010;

endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
   import smm_win_pkg::*;
#(
   parameter int         CFG_AW   = 2,
   parameter int         CTRL_SEL = 0,
   parameter int         EXT_SEL  = 1,
   parameter logic [2:0] SEG_CODE = SEG_CODE_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output smm_ctrl_t         ctrl_o,
   output smm_ext_t          ext_o
);

   localparam logic [CFG_AW-1:0] CTRL_A = CFG_AW'(CTRL_SEL);
   localparam logic [CFG_AW-1:0] EXT_A  = CFG_AW'(EXT_SEL);

   smm_ctrl_t ctrl_q;
   smm_ext_t  ext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '{rsvd: 1'b0, open: 1'b0, cls: 1'b0, lck: 1'b0, en: 1'b0, seg: SEG_CODE};
         ext_q  <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == CTRL_A) begin
            if (ctrl_q.lck) begin
               ctrl_q.cls <= cfg_wdata[5];
            end else begin
               ctrl_q.open <= cfg_wdata[6] & ~cfg_wdata[4];
               ctrl_q.cls  <= cfg_wdata[5];
               ctrl_q.lck  <= cfg_wdata[4];
               ctrl_q.en   <= cfg_wdata[3];
            end
         end
         if (cfg_addr == EXT_A) begin
            ext_q.alias_on <= cfg_wdata[7];
            ext_q.tsize    <= cfg_wdata[2:1];
            ext_q.tseg_on  <= cfg_wdata[0];
         end
      end
   end

   always_comb begin
      cfg_rdata = 8'h00;
      if (cfg_addr == CTRL_A) cfg_rdata = ctrl_q;
      else if (cfg_addr == EXT_A) cfg_rdata = ext_q;
   end

   assign ctrl_o = ctrl_q;
   assign ext_o  = ext_q;

   // R4: lock can only be left through reset
   p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.lck |=> ctrl_q.lck);

   // R4: frozen fields hold while locked
   p_lock_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.lck |=> ($stable(ctrl_q.open) && $stable(ctrl_q.en) && $stable(ctrl_q.seg)));

   // R3: the cycle the lock appears, open is already shut
   p_lock_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.lck) |-> !ctrl_q.open);

endmodule

// File: rtl/smm_tseg_range.sv
module smm_tseg_range #(
   parameter int ADDR_W    = 32,
   parameter int UNIT_LOG2 = 17
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] tom,
   input  logic              tseg_en,
   input  logic [1:0]        tsize,
   output logic              tseg_hit
);

   localparam logic [ADDR_W-1:0] UNIT = ADDR_W'(1) << UNIT_LOG2;

   logic [ADDR_W-1:0] seg_size;
   logic [ADDR_W-1:0] seg_lo;

   assign seg_size = UNIT << tsize;
   assign seg_lo   = tom - seg_size;
   assign tseg_hit = tseg_en && (acc_addr >= seg_lo) && (acc_addr < tom);

endmodule

// File: rtl/smm_route_dec.sv
module smm_route_dec #(
   parameter int              ADDR_W     = 32,
   parameter bit              ALIAS_EN   = 1'b1,
   parameter longint unsigned LEG_BASE   = 64'h000A_0000,
   parameter longint unsigned LEG_SIZE   = 64'h0002_0000,
   parameter longint unsigned ALIAS_BASE = 64'h100A_0000,
   parameter longint unsigned ALIAS_SIZE = 64'h0006_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] tom,
   input  logic              ctrl_open,
   input  logic              ctrl_cls,
   input  logic              ctrl_lck,
   input  logic              ctrl_en,
   input  logic              alias_req,
   input  logic              tseg_hit,
   output logic              route_dram,
   output logic [ADDR_W-1:0] dram_addr
);

   localparam logic [ADDR_W-1:0] LEG_LO   = ADDR_W'(LEG_BASE);
   localparam logic [ADDR_W-1:0] LEG_HI   = ADDR_W'(LEG_BASE + LEG_SIZE);
   localparam logic [ADDR_W-1:0] ALI_LO   = ADDR_W'(ALIAS_BASE);
   localparam logic [ADDR_W-1:0] ALI_HI   = ADDR_W'(ALIAS_BASE + ALIAS_SIZE);
   localparam logic [ADDR_W-1:0] ALI_XLAT = ADDR_W'(ALIAS_BASE - LEG_BASE);

   logic leg_hit, alias_on, alias_hit, low_win, smram_hit, grant;

   assign leg_hit = (acc_addr >= LEG_LO) && (acc_addr < LEG_HI);

   generate
      if (ALIAS_EN) begin : g_alias
         assign alias_on  = alias_req;
         assign alias_hit = alias_req && (acc_addr >= ALI_LO) && (acc_addr < ALI_HI);
      end else begin : g_no_alias
         logic unused_alias;
         assign unused_alias = alias_req;
         assign alias_on  = 1'b0;
         assign alias_hit = 1'b0;
      end
   endgenerate

   assign low_win   = leg_hit && !alias_on;
   assign smram_hit = low_win || alias_hit;

   always_comb begin
      if (!ctrl_en)     grant = 1'b0;
      else if (acc_smm) grant = !(ctrl_cls && acc_write);
      else              grant = ctrl_open && !ctrl_cls && !ctrl_lck;
   end

   always_comb begin
      if (smram_hit)     route_dram = grant;
      else if (leg_hit)  route_dram = 1'b0;
      else if (tseg_hit) route_dram = acc_smm;
      else               route_dram = (acc_addr < tom);
   end

   assign dram_addr = alias_hit ? (acc_addr - ALI_XLAT) : acc_addr;

   // R5: a locked window is never visible outside system-management mode
   p_locked_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_smm && ctrl_lck && smram_hit) |-> !route_dram);

   // R7: global enable off keeps both protected views on the bus
   p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && smram_hit) |-> !route_dram);

   // R8: a granted alias access lands inside the legacy DRAM range
   p_alias_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alias_hit && route_dram) |-> (dram_addr >= LEG_LO && dram_addr < ALI_HI - ALI_XLAT));

   // R10: top segment closed to ordinary accesses
   p_tseg_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tseg_hit && !leg_hit && !alias_hit && !acc_smm) |-> !route_dram);

endmodule

// File: rtl/smm_window_ctl.sv
module smm_window_ctl
   import smm_win_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CFG_AW    = 2,
   parameter int CTRL_SEL  = 0,
   parameter int EXT_SEL   = 1,
   parameter bit ALIAS_EN  = 1'b1,
   parameter int UNIT_LOG2 = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] tom,
   output logic              route_dram,
   output logic [ADDR_W-1:0] dram_addr
);

   localparam int MIN_AW = ALIAS_EN ? 29 : 20;

   generate
      if (ADDR_W < MIN_AW) begin : g_bad_aw
         $error("ADDR_W too narrow for the configured windows");
      end
      if (CTRL_SEL == EXT_SEL) begin : g_bad_sel
         $error("register selects must differ");
      end
      if (CTRL_SEL >= (1 << CFG_AW) || EXT_SEL >= (1 << CFG_AW)) begin : g_bad_cfg
         $error("register select outside CFG_AW range");
      end
   endgenerate

   smm_ctrl_t ctrl;
   smm_ext_t  ext;
   logic      tseg_hit;

   smm_cfg_regs #(
      .CFG_AW   (CFG_AW),
      .CTRL_SEL (CTRL_SEL),
      .EXT_SEL  (EXT_SEL),
      .SEG_CODE (SEG_CODE_DEF)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .ctrl_o    (ctrl),
      .ext_o     (ext)
   );

   smm_tseg_range #(
      .ADDR_W    (ADDR_W),
      .UNIT_LOG2 (UNIT_LOG2)
   ) u_tseg (
      .acc_addr (acc_addr),
      .tom      (tom),
      .tseg_en  (ctrl.en & ext.tseg_on),
      .tsize    (ext.tsize),
      .tseg_hit (tseg_hit)
   );

   smm_route_dec #(
      .ADDR_W   (ADDR_W),
      .ALIAS_EN (ALIAS_EN)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_addr   (acc_addr),
      .acc_smm    (acc_smm),
      .acc_write  (acc_write),
      .tom        (tom),
      .ctrl_open  (ctrl.open),
      .ctrl_cls   (ctrl.cls),
      .ctrl_lck   (ctrl.lck),
      .ctrl_en    (ctrl.en),
      .alias_req  (ext.alias_on),
      .tseg_hit   (tseg_hit),
      .route_dram (route_dram),
      .dram_addr  (dram_addr)
   );

endmodule

// File: tb/sim_smm_window_ctl.sv
`timescale 1ns/1ps
module sim_smm_window_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic [31:0] acc_addr = 32'h0;
   logic        acc_smm = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] tom = 32'h0400_0000;
   logic        route_dram;
   logic [31:0] dram_addr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] mc = 8'h02;
   logic [7:0] mx = 8'h00;

   always #2.5 clk = ~clk;

   smm_window_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
      .acc_smm(acc_smm), .acc_write(acc_write), .tom(tom),
      .route_dram(route_dram), .dram_addr(dram_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      mc = 8'h02; mx = 8'h00;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 2'd0) begin
         if (mc[4]) mc[5] = d[5];
         else mc = {1'b0, d[6] & ~d[4], d[5], d[4], d[3], mc[2:0]};
      end else if (a == 2'd1) begin
         mx = d & 8'h87;
      end
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
      cfg_addr = a; #1;
      check(req, {24'h0, cfg_rdata}, {24'h0, exp});
   endtask

   function automatic bit exp_route(input logic [31:0] a, input bit smm, input bit w);
      bit en, al, low, hi, grant;
      logic [31:0] sz;
      en  = mc[3];
      al  = mx[7];
      low = (a >= 32'h000A_0000) && (a < 32'h000C_0000);
      hi  = al && (a >= 32'h100A_0000) && (a < 32'h1010_0000);
      if (!en) grant = 0;
      else if (smm) grant = !(mc[5] && w);
      else grant = (mc[6:4] == 3'b100);
      sz = 32'h0002_0000 << mx[2:1];
      if (hi || (low && !al)) return grant;
      if (low) return 0;
      if (en && mx[0] && a >= tom - sz && a < tom) return smm;
      return a < tom;
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] a);
      if (mx[7] && a >= 32'h100A_0000 && a < 32'h1010_0000) return a - 32'h1000_0000;
      return a;
   endfunction

   task automatic acc(input string req, input logic [31:0] a, input bit smm, input bit w);
      @(negedge clk);
      acc_addr = a; acc_smm = smm; acc_write = w; #1;
      check(req, {31'h0, route_dram}, {31'h0, exp_route(a, smm, w)});
      check(req, dram_addr, exp_addr(a));
   endtask

   function automatic logic [31:0] pick_addr();
      int r;
      r = $urandom_range(0, 5);
      case (r)
         0: return 32'h000A_0000 + $urandom_range(0, 32'h1FFFF);
         1: return 32'h100A_0000 + $urandom_range(0, 32'h5FFFF);
         2: return tom - 32'h0010_0000 + $urandom_range(0, 32'h10_00FF) - 32'h80;
         3: return $urandom_range(0, 32'h0003_FFFF) * 256;
         4: return tom + $urandom_range(0, 32'hFFFF) - 32'h10;
         default: return (r == 5 && $urandom_range(0, 1) == 1) ? 32'h0009_FFFF : 32'h000C_0000;
      endcase
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values and unused addresses
      rd("R1", 2'd0, 8'h02);
      rd("R1", 2'd1, 8'h00);
      rd("R1", 2'd2, 8'h00);
      rd("R1", 2'd3, 8'h00);

      // R2 field loading and reserved bits
      wr(2'd0, 8'hC8); rd("R2", 2'd0, 8'h4A);
      wr(2'd1, 8'hFF); rd("R2", 2'd1, 8'h87);
      wr(2'd1, 8'h00); rd("R2", 2'd1, 8'h00);

      // R5 open window outside SMM, then close blocks it
      acc("R5", 32'h000A_0000, 0, 0);
      acc("R5", 32'h000B_FFFF, 0, 1);
      wr(2'd0, 8'h68);
      acc("R5", 32'h000A_1234, 0, 0);
      check("R5", {31'h0, route_dram}, 32'h0);

      // R6 SMM close splits reads and writes
      acc("R6", 32'h000B_0000, 1, 0);
      check("R6", {31'h0, route_dram}, 32'h1);
      acc("R6", 32'h000B_0000, 1, 1);
      check("R6", {31'h0, route_dram}, 32'h0);
      wr(2'd0, 8'h08);
      acc("R6", 32'h000B_0000, 1, 1);
      check("R6", {31'h0, route_dram}, 32'h1);

      // R7 enable off
      wr(2'd0, 8'h40);
      acc("R7", 32'h000A_0000, 1, 0);
      check("R7", {31'h0, route_dram}, 32'h0);
      acc("R7", 32'h000A_0000, 0, 0);

      // R8 high alias
      wr(2'd0, 8'h08); wr(2'd1, 8'h80);
      acc("R8", 32'h100A_0000, 1, 0);
      check("R8", dram_addr, 32'h000A_0000);
      acc("R8", 32'h100F_FFFF, 1, 1);
      check("R8", dram_addr, 32'h000F_FFFF);
      acc("R8", 32'h000A_0000, 1, 0);
      check("R8", {31'h0, route_dram}, 32'h0);
      acc("R8", 32'h1010_0000, 1, 0);

      // R9 / R10 top segment edges for each size
      for (int s = 0; s < 4; s++) begin
         wr(2'd1, {5'b0, 2'(s), 1'b1});
         acc("R9", tom - (32'h0002_0000 << s), 1, 0);
         acc("R9", tom - (32'h0002_0000 << s) - 1, 0, 0);
         acc("R10", tom - 1, 1, 1);
         acc("R10", tom - 1, 0, 0);
         check("R10", {31'h0, route_dram}, 32'h0);
      end
      wr(2'd0, 8'h00);
      acc("R9", tom - 1, 0, 0);
      check("R9", {31'h0, route_dram}, 32'h1);

      // R11 ordinary memory
      acc("R11", 32'h0000_1000, 0, 1);
      acc("R11", tom, 1, 0);
      check("R11", {31'h0, route_dram}, 32'h0);

      // R3 lock shuts open; R4 frozen except close, reset unlocks
      wr(2'd0, 8'h58); rd("R3", 2'd0, 8'h1A);
      acc("R3", 32'h000A_0000, 0, 0);
      wr(2'd0, 8'h20); rd("R4", 2'd0, 8'h3A);
      wr(2'd0, 8'h40); rd("R4", 2'd0, 8'h1A);
      do_reset();
      rd("R4", 2'd0, 8'h02);
      wr(2'd0, 8'h48); rd("R4", 2'd0, 8'h4A);

      // mixed random traffic
      tom = 32'h0200_0000;
      for (int i = 0; i < 4000; i++) begin
         int op;
         op = $urandom_range(0, 99);
         if (op < 1) begin
            do_reset();
            rd("R1", 2'd0, 8'h02);
         end else if (op < 9) begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom_range(0, 9) != 0) d[4] = 1'b0;
            wr(2'd0, d);
            rd("R4", 2'd0, mc);
         end else if (op < 14) begin
            wr(2'd1, 8'($urandom));
            rd("R2", 2'd1, mx);
         end else begin
            acc("R11", pick_addr(), 1'($urandom), 1'($urandom));
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule